// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Alarms

This block keeps time in milliseconds and seconds from a slow timekeeping tick of nominally 32768 Hz. The tick is a single-cycle enable on the system clock, so every timekeeping register advances only on cycles where `tick_i` is high. A fractional accumulator turns the 32768 ticks of each second into exactly 1000 millisecond steps. A seconds counter advances on every thousandth millisecond step.

Software sees the time through a bus view that is refreshed once every eight ticks. On the same boundary, pending writes to the alarm, mask and countdown registers move into the timekeeping logic. A busy bit shows when a refresh is imminent or a write has not yet been applied. Reading the milliseconds register also captures the visible seconds into a shadow register, so a milliseconds read followed by a shadow read gives one coherent timestamp.

Five event sources feed a status register: two seconds match alarms, one milliseconds match alarm, a seconds countdown and a milliseconds countdown. Software clears status bits by writing ones to them. A single interrupt line is raised by any status bit whose mask bit is set.

Top module: `rtc_ms_alarm`

## Requirements
- R1: After N ticks since reset, the millisecond count is floor(N*1000/32768) and the second count is floor(milliseconds/1000).
- R2: The bus view of seconds (offset 0x08) and milliseconds (offset 0x10) is loaded on every tick whose number since reset is a multiple of 8. Between two such ticks it holds the values from the last one.
- R3: Bit 0 of the busy register (offset 0x04) reads 1 when the tick count since reset is 7 modulo 8. It also reads 1 while any staged write is waiting to be applied. Otherwise it reads 0.
- R4: A read of the milliseconds register copies the visible seconds into the shadow register (offset 0x0C). The shadow keeps that value until the next milliseconds read.
- R5: Status bit 0 (alarm at offset 0x14) or bit 1 (alarm at offset 0x18) sets when the second count steps to a value equal to that alarm.
- R6: Status bit 2 sets when the millisecond count steps to a value equal to the milliseconds alarm (offset 0x1C).
- R7: The countdown registers (seconds at 0x20, milliseconds at 0x24) take bit 31 as the arm flag and bits 27:0 as the count. An armed countdown loaded with C counts down on each step of its unit. On step max(C,1) after loading, it sets its status bit (bit 3 for seconds, bit 4 for milliseconds), clears its count and clears its arm flag.
- R8: Writing 0 to an armed countdown disarms it, and it sets no status bit afterwards.
- R9: Writing the status register (offset 0x2C) clears each bit written as 1 and leaves each bit written as 0 unchanged. Events set their status bit regardless of the mask, and an event wins over a clear in the same cycle.
- R10: `irq_o` is high exactly when some status bit and the same bit of the applied mask (offset 0x28, bits 4:0) are both 1.
- R11: Writes to the alarm, countdown and mask registers take effect on the next tick whose number is a multiple of 8. A read of an alarm or mask register returns the last written value at once. A read of a countdown returns the staged value while a write is pending, and the live value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timekeeping tick enable, one cycle per 32 kHz period |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the seconds alarms and the seconds countdown. The first whole second takes 32768 ticks, and a deferred write is visible only across a copy boundary. The bench drives `tick_i` continuously in bursts and holds it low during every register access, so the tick count is exact. The phase, the visible time and the cycle of each event can therefore be predicted and sampled one tick before and at the tick where they change. The countdown is loaded and then disarmed inside a single copy window with no millisecond step in it. This shows that the zero write, not a decrement, ends the countdown.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CD_W      = 28;
  localparam int unsigned CD_EN_BIT = 31;
  localparam int unsigned NUM_IRQ   = 5;
  localparam int unsigned NUM_CD    = 2;
  localparam int unsigned NFULL     = 5;          // full-width staged registers
  localparam int unsigned NCFG      = NFULL + 1;  // plus the mask

  localparam logic [ADDR_W-1:0] OFS_BUSY   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_SEC    = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_SHADOW = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_MS     = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_SALM0  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_SALM1  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MALM   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_SCD    = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MCD    = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h2C;

  // staged register index; countdowns adjacent, seconds first
  localparam int unsigned CFG_SALM0 = 0;
  localparam int unsigned CFG_SALM1 = 1;
  localparam int unsigned CFG_MALM  = 2;
  localparam int unsigned CFG_SCD   = 3;
  localparam int unsigned CFG_MCD   = 4;
  localparam int unsigned CFG_MASK  = 5;

  // interrupt bit positions, shared by mask and status
  localparam int unsigned IRQ_SALM0 = 0;
  localparam int unsigned IRQ_SALM1 = 1;
  localparam int unsigned IRQ_MALM  = 2;
  localparam int unsigned IRQ_SCD   = 3;
  localparam int unsigned IRQ_MCD   = 4;

  function automatic logic [ADDR_W-1:0] cfg_ofs(input int unsigned idx);
    case (idx)
      CFG_SALM0: return OFS_SALM0;
      CFG_SALM1: return OFS_SALM1;
      CFG_MALM:  return OFS_MALM;
      CFG_SCD:   return OFS_SCD;
      CFG_MCD:   return OFS_MCD;
      default:   return OFS_MASK;
    endcase
  endfunction
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int unsigned TICK_HZ    = 32768,
  parameter int unsigned MS_PER_S   = 1000,
  parameter int unsigned COPY_TICKS = 8,
  parameter int unsigned CNT_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             ms_step_o,
  output logic             sec_step_o,
  output logic             copy_phase_o,
  output logic             copy_o,
  output logic [CNT_W-1:0] ms_next_o,
  output logic [CNT_W-1:0] sec_next_o
);
  localparam int unsigned PH_W  = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
  localparam int unsigned ACC_W = $clog2(TICK_HZ + MS_PER_S) + 1;
  localparam int unsigned SUB_W = (MS_PER_S > 1) ? $clog2(MS_PER_S) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(COPY_TICKS - 1);
  localparam logic [ACC_W-1:0] ACC_INC  = ACC_W'(MS_PER_S);
  localparam logic [ACC_W-1:0] ACC_WRAP = ACC_W'(TICK_HZ);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(MS_PER_S - 1);

  logic [PH_W-1:0]  phase_q;
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] ms_q, sec_q;

  always_comb begin
    acc_sum      = acc_q + ACC_INC;
    ms_step_o    = tick_i && (acc_sum >= ACC_WRAP);
    sec_step_o   = ms_step_o && (sub_q == SUB_LAST);
    ms_next_o    = ms_q + CNT_W'(ms_step_o);
    sec_next_o   = sec_q + CNT_W'(sec_step_o);
    copy_phase_o = (phase_q == PH_LAST);
    copy_o       = tick_i && copy_phase_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      acc_q   <= '0;
      sub_q   <= '0;
      ms_q    <= '0;
      sec_q   <= '0;
    end else if (tick_i) begin
      phase_q <= copy_phase_o ? '0 : phase_q + 1'b1;
      acc_q   <= ms_step_o ? acc_sum - ACC_WRAP : acc_sum;
      if (ms_step_o) sub_q <= sec_step_o ? '0 : sub_q + 1'b1;
      ms_q    <= ms_next_o;
      sec_q   <= sec_next_o;
    end
  end
endmodule

// File: rtl/rtc_countdown.sv
module rtc_countdown #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CD_W   = 28,
  parameter int unsigned EN_BIT = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_en_i,
  input  logic [CD_W-1:0]   load_cnt_i,
  input  logic              step_i,
  output logic              fire_o,
  output logic              en_o,
  output logic [DATA_W-1:0] value_o
);
  logic            en_q;
  logic [CD_W-1:0] cnt_q;
  logic            last;

  always_comb begin
    last    = (cnt_q <= CD_W'(1));
    fire_o  = !load_i && en_q && step_i && last;
    en_o    = en_q;
    value_o = '0;
    value_o[EN_BIT]   = en_q;
    value_o[CD_W-1:0] = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      en_q  <= load_en_i;
      cnt_q <= load_cnt_i;
    end else if (en_q && step_i) begin
      if (last) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         copy_i,
  input  logic                         copy_phase_i,
  input  logic [DATA_W-1:0]            ms_next_i,
  input  logic [DATA_W-1:0]            sec_next_i,
  input  logic [NUM_IRQ-1:0]           events_i,
  input  logic [NUM_CD-1:0][DATA_W-1:0] cd_live_i,
  output logic [NFULL-1:0][DATA_W-1:0] stage_o,
  output logic [NCFG-1:0]              pending_o,
  output logic [DATA_W-1:0]            salm0_o,
  output logic [DATA_W-1:0]            salm1_o,
  output logic [DATA_W-1:0]            malm_o,
  output logic [NUM_IRQ-1:0]           status_o,
  output logic [NUM_IRQ-1:0]           mask_o,
  output logic [DATA_W-1:0]            view_ms_o,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         rvalid_o,
  output logic                         irq_o
);
  logic [NFULL-1:0][DATA_W-1:0] stage_q;
  logic [NUM_IRQ-1:0]           mask_stage_q, mask_live_q;
  logic [NCFG-1:0]              wr_hit, pending_q;
  logic [DATA_W-1:0]            salm0_q, salm1_q, malm_q;
  logic [DATA_W-1:0]            view_ms_q, view_sec_q, shadow_q;
  logic [NUM_IRQ-1:0]           status_q, clr_bits;
  logic [DATA_W-1:0]            rd_mux, rdata_q;
  logic                         rvalid_q, busy, stat_wr;

  always_comb begin
    for (int k = 0; k < NCFG; k++) wr_hit[k] = wr_en_i && (addr_i == cfg_ofs(k));
    stat_wr  = wr_en_i && (addr_i == OFS_STAT);
    clr_bits = stat_wr ? wdata_i[NUM_IRQ-1:0] : '0;
    busy     = copy_phase_i || (|pending_q);
  end

  // staged side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q      <= '0;
      mask_stage_q <= '0;
      pending_q    <= '0;
    end else begin
      for (int k = 0; k < NFULL; k++) if (wr_hit[k]) stage_q[k] <= wdata_i;
      if (wr_hit[CFG_MASK]) mask_stage_q <= wdata_i[NUM_IRQ-1:0];
      // a write in the copy cycle stays pending for the next boundary
      pending_q <= wr_hit | (pending_q & ~{NCFG{copy_i}});
    end
  end

  // applied side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      salm0_q     <= '0;
      salm1_q     <= '0;
      malm_q      <= '0;
      mask_live_q <= '0;
      view_ms_q   <= '0;
      view_sec_q  <= '0;
    end else if (copy_i) begin
      if (pending_q[CFG_SALM0]) salm0_q     <= stage_q[CFG_SALM0];
      if (pending_q[CFG_SALM1]) salm1_q     <= stage_q[CFG_SALM1];
      if (pending_q[CFG_MALM])  malm_q      <= stage_q[CFG_MALM];
      if (pending_q[CFG_MASK])  mask_live_q <= mask_stage_q;
      view_ms_q  <= ms_next_i;
      view_sec_q <= sec_next_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_bits) | events_i;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFS_BUSY:   rd_mux[0] = busy;
      OFS_SEC:    rd_mux = view_sec_q;
      OFS_SHADOW: rd_mux = shadow_q;
      OFS_MS:     rd_mux = view_ms_q;
      OFS_SALM0:  rd_mux = stage_q[CFG_SALM0];
      OFS_SALM1:  rd_mux = stage_q[CFG_SALM1];
      OFS_MALM:   rd_mux = stage_q[CFG_MALM];
      OFS_SCD:    rd_mux = pending_q[CFG_SCD] ? stage_q[CFG_SCD] : cd_live_i[0];
      OFS_MCD:    rd_mux = pending_q[CFG_MCD] ? stage_q[CFG_MCD] : cd_live_i[1];
      OFS_MASK:   rd_mux[NUM_IRQ-1:0] = mask_stage_q;
      OFS_STAT:   rd_mux[NUM_IRQ-1:0] = status_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      shadow_q <= '0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
      if (rd_en_i && (addr_i == OFS_MS)) shadow_q <= view_sec_q;
    end
  end

  assign stage_o   = stage_q;
  assign pending_o = pending_q;
  assign salm0_o   = salm0_q;
  assign salm1_o   = salm1_q;
  assign malm_o    = malm_q;
  assign status_o  = status_q;
  assign mask_o    = mask_live_q;
  assign view_ms_o = view_ms_q;
  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;
  assign irq_o     = |(status_q & mask_live_q);
endmodule

// File: rtl/rtc_ms_alarm.sv
module rtc_ms_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned TICK_HZ    = 32768,
  parameter int unsigned MS_PER_S   = 1000,
  parameter int unsigned COPY_TICKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic                          ms_step, sec_step, copy_phase, copy;
  logic [DATA_W-1:0]             ms_next, sec_next;
  logic [NFULL-1:0][DATA_W-1:0]  stage;
  logic [NCFG-1:0]               pending;
  logic [DATA_W-1:0]             salm0, salm1, malm, view_ms;
  logic [NUM_IRQ-1:0]            status, mask, events;
  logic [NUM_CD-1:0][DATA_W-1:0] cd_live;
  logic [NUM_CD-1:0]             cd_step, cd_fire, cd_en;

  rtc_timebase #(
    .TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S), .COPY_TICKS(COPY_TICKS), .CNT_W(DATA_W)
  ) i_timebase (
    .clk_i, .rst_ni, .tick_i,
    .ms_step_o(ms_step), .sec_step_o(sec_step),
    .copy_phase_o(copy_phase), .copy_o(copy),
    .ms_next_o(ms_next), .sec_next_o(sec_next)
  );

  assign cd_step = {ms_step, sec_step};

  for (genvar g = 0; g < NUM_CD; g++) begin : g_cd
    rtc_countdown #(.DATA_W(DATA_W), .CD_W(CD_W), .EN_BIT(CD_EN_BIT)) i_cd (
      .clk_i, .rst_ni,
      .load_i(copy && pending[CFG_SCD+g]),
      .load_en_i(stage[CFG_SCD+g][CD_EN_BIT]),
      .load_cnt_i(stage[CFG_SCD+g][CD_W-1:0]),
      .step_i(cd_step[g]),
      .fire_o(cd_fire[g]),
      .en_o(cd_en[g]),
      .value_o(cd_live[g])
    );
  end

  always_comb begin
    events            = '0;
    events[IRQ_SALM0] = sec_step && (sec_next == salm0);
    events[IRQ_SALM1] = sec_step && (sec_next == salm1);
    events[IRQ_MALM]  = ms_step && (ms_next == malm);
    events[IRQ_SCD]   = cd_fire[0];
    events[IRQ_MCD]   = cd_fire[1];
  end

  rtc_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .copy_i(copy), .copy_phase_i(copy_phase),
    .ms_next_i(ms_next), .sec_next_i(sec_next),
    .events_i(events), .cd_live_i(cd_live),
    .stage_o(stage), .pending_o(pending),
    .salm0_o(salm0), .salm1_o(salm1), .malm_o(malm),
    .status_o(status), .mask_o(mask), .view_ms_o(view_ms),
    .rdata_o, .rvalid_o, .irq_o
  );
endmodule

// File: rtl/rtc_ms_alarm_chk.sv
module rtc_ms_alarm_chk
  import rtc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               wr_en_i,
  input logic               irq_o,
  input logic               copy_i,
  input logic [NUM_IRQ-1:0] status_i,
  input logic [NUM_IRQ-1:0] mask_i,
  input logic [DATA_W-1:0]  view_ms_i,
  input logic [NCFG-1:0]    pending_i,
  input logic [NUM_CD-1:0]  cd_en_i,
  input logic [NUM_CD-1:0]  cd_fire_i
);
  // R2: bus view moves only on a copy tick
  p_view_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !copy_i |=> $stable(view_ms_i));

  // R9: with no write and no tick, status cannot change
  p_status_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !tick_i) |=> $stable(status_i));

  // R10: no pending cause, no interrupt
  p_irq_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i & mask_i) == '0) |-> !irq_o);

  // R7: a firing countdown disarms itself and flags status
  p_scd_disarm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_fire_i[0] |=> (!cd_en_i[0] && status_i[IRQ_SCD]));

  p_mcd_disarm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_fire_i[1] |=> (!cd_en_i[1] && status_i[IRQ_MCD]));

  // R11: a copy with no concurrent write drains every staged write
  p_pending_drain_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_i && !wr_en_i) |=> (pending_i == '0));
endmodule

bind rtc_ms_alarm rtc_ms_alarm_chk i_rtc_ms_alarm_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .irq_o(irq_o), .copy_i(copy), .status_i(status), .mask_i(mask),
  .view_ms_i(view_ms), .pending_i(pending), .cd_en_i(cd_en), .cd_fire_i(cd_fire)
);

// File: tb/test_rtc_ms_alarm.sv
module test_rtc_ms_alarm;
  localparam longint HZ = 32768;
  localparam longint MPS = 1000;
  localparam longint GRP = 8;
  localparam logic [5:0] A_BUSY = 6'h04, A_SEC = 6'h08, A_SHD = 6'h0C, A_MS = 6'h10;
  localparam logic [5:0] A_SA0 = 6'h14, A_SA1 = 6'h18, A_MA = 6'h1C;
  localparam logic [5:0] A_SCD = 6'h20, A_MCD = 6'h24, A_MSK = 6'h28, A_STA = 6'h2C;

  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, irq_o;

  int          total = 0, fails = 0;
  longint      n_ticks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_exp;
  string       m_tag;

  always #5 clk_i = ~clk_i;

  rtc_ms_alarm i_rtc_ms_alarm (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .rdata_o, .rvalid_o, .irq_o
  );

  function automatic logic [31:0] ms_of(input longint n);
    return 32'((n * MPS) / HZ);
  endfunction

  function automatic logic [31:0] view_ms(input longint n);
    return ms_of((n / GRP) * GRP);
  endfunction

  function automatic logic [31:0] view_sec(input longint n);
    return view_ms(n) / 32'(MPS);
  endfunction

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      total++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: actual %h expected none", rdata_o);
      end else begin
        m_exp = exp_q.pop_front();
        m_tag = tag_q.pop_front();
        if (rdata_o !== m_exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", m_tag, rdata_o, m_exp);
        end
      end
    end
  end

  task automatic run_ticks(input longint k);
    for (longint i = 0; i < k; i++) begin
      @(negedge clk_i); tick_i = 1'b1; n_ticks++;
    end
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic run_to(input longint target);
    run_ticks(target - n_ticks);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk_i); rd_en_i = 1'b1; addr_i = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    total++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    rd(A_BUSY, 32'h0, "R3 busy after reset");
    rd(A_MS, 32'h0, "R2 ms view after reset");
    rd(A_STA, 32'h0, "R9 status after reset");
    chk({31'h0, irq_o}, 32'h0, "R10 irq after reset");

    run_to(7);
    rd(A_BUSY, 32'h1, "R3 busy at phase 7");
    run_to(231);
    rd(A_MS, view_ms(231), "R2 ms view holds last copy");
    rd(A_SEC, 32'h0, "R1 seconds before first second");

    run_to(232);
    rd(A_BUSY, 32'h0, "R3 idle after copy");
    wr(A_MA, 32'd10);
    rd(A_BUSY, 32'h1, "R3 busy with pending write");
    rd(A_MA, 32'd10, "R11 alarm readback");
    run_to(240);
    rd(A_BUSY, 32'h0, "R11 pending applied at boundary");

    run_to(327);
    rd(A_STA, 32'h0, "R6 ms alarm before match");
    run_to(328);
    rd(A_STA, 32'h4, "R6 ms alarm on match");
    chk({31'h0, irq_o}, 32'h0, "R9 status set while masked");

    wr(A_MSK, 32'h4);
    rd(A_MSK, 32'h4, "R11 mask readback");
    chk({31'h0, irq_o}, 32'h0, "R11 mask not yet applied");
    run_to(335);
    chk({31'h0, irq_o}, 32'h0, "R11 mask not applied before boundary");
    run_to(336);
    chk({31'h0, irq_o}, 32'h1, "R10 irq after mask applied");

    wr(A_STA, 32'h1B);
    rd(A_STA, 32'h4, "R9 zero bits leave status");
    wr(A_STA, 32'h4);
    rd(A_STA, 32'h0, "R9 one bit clears status");
    chk({31'h0, irq_o}, 32'h0, "R10 irq drops after clear");

    wr(A_MCD, 32'h8000_0005);
    run_to(344);
    run_to(491);
    rd(A_MCD, 32'h8000_0001, "R7 ms countdown one left");
    rd(A_STA, 32'h0, "R7 ms countdown not yet fired");
    run_to(492);
    rd(A_STA, 32'h10, "R7 ms countdown fired");
    rd(A_MCD, 32'h0, "R7 ms countdown disarmed");
    chk({31'h0, irq_o}, 32'h0, "R10 unmasked bit gives no irq");
    wr(A_STA, 32'h10);

    run_to(496);
    wr(A_MCD, 32'h8000_0003);
    run_to(504);
    rd(A_MCD, 32'h8000_0003, "R11 countdown loaded at boundary");
    wr(A_MCD, 32'h0);
    run_to(512);
    run_to(700);
    rd(A_MCD, 32'h0, "R8 countdown disarmed by zero");
    rd(A_STA, 32'h0, "R8 no fire after disarm");

    run_to(704);
    wr(A_SA0, 32'd1);
    wr(A_SA1, 32'd2);
    wr(A_SCD, 32'h8000_0002);
    run_to(712);
    run_to(32767);
    rd(A_STA, 32'h0, "R5 seconds alarm before match");
    run_to(32768);
    rd(A_STA, 32'h1, "R5 seconds alarm 0 on match");
    wr(A_STA, 32'h1);

    run_to(65535);
    rd(A_STA, 32'h0, "R5 second alarm 1 before match");
    run_to(65536);
    rd(A_STA, 32'h0A, "R5 R7 alarm 1 and seconds countdown");
    rd(A_SEC, view_sec(65536), "R1 two seconds elapsed");
    wr(A_STA, 32'h0A);

    run_to(65576);
    rd(A_MS, view_ms(65576), "R1 ms count after two seconds");
    rd(A_SHD, 32'd2, "R4 shadow captured on ms read");
    run_to(98312);
    rd(A_SHD, 32'd2, "R4 shadow holds until ms read");
    rd(A_SEC, view_sec(98312), "R2 seconds view three");
    rd(A_MS, view_ms(98312), "R2 ms view three seconds");
    rd(A_SHD, 32'd3, "R4 shadow refreshed");

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      total++; fails++;
      $display("FAIL scoreboard: actual %0d reads missing expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule